// File: doc/BRIEF.md
# Half-Duplex Transmit Backoff and Deferral Controller

This block decides when a half-duplex Ethernet transmitter may start a frame. Once a frame is requested, the controller waits for the carrier to go quiet, then issues a one-cycle start strobe. If the attempt collides, it draws a random wait of whole slot times and tries again. The random draw is bounded by an exponent that grows with the number of collisions and is capped by a programmable limit. It gives up after too many collisions, or at once when retries are disabled. An optional watchdog limits how long the controller may defer to a busy carrier.

All timing is counted in bit times, given by a one-cycle tick input. One slot is `SLOT_BITS` ticks (512 by default). The deferral watchdog limit is `DEFER_STD` ticks (24288), or `DEFER_JUMBO` ticks (155680) when jumbo mode is on. The serializer and the media interface lie outside the block. They report the end of a frame through `done_i` and a collision through `col_i`.

Top module: `hdx_txctl`

## Requirements
- R1: While `rst_i` is high and in the cycle after it is released with no request, `go_o`, `retry_o` and `abort_o` are low and `abort_cause_o` is 0.
- R2: With a request pending and the carrier idle, `go_o` pulses two cycles after `req_i` is first seen. When the carrier is busy, `go_o` pulses one cycle after the first cycle in which carrier sense is seen low during deferral.
- R3: With the deferral check on, the attempt is aborted on the tick that makes continuous deferral exceed the limit: the `DEFER_STD`+1-th tick, or the `DEFER_JUMBO`+1-th tick when `jumbo_i` is high. The abort is one cycle after that tick, with `abort_cause_o` = 2 (excessive deferral).
- R4: With the deferral check off, the controller waits for carrier sense to drop for as long as it stays high, and never aborts for deferral.
- R5: Deferral time advances only on cycles with `tick_i` high. Cycles without a tick never cause a deferral abort.
- R6: A collision during transmission, with retries allowed and attempts remaining, pulses `retry_o` one cycle later. `go_o` follows `r`×`SLOT_BITS` ticks plus two cycles after the retry strobe, where `r` is a whole number of slots.
- R7: After the n-th collision of a frame, `r` lies in 0 ≤ r < 2^k with k = min(n, L). L is 10, 8, 4 or 1 for `backoff_lim_i` codes 0, 1, 2 and 3.
- R8: With `no_retry_i` high, the first collision aborts the frame one cycle later with `abort_cause_o` = 1 (excessive collisions) and no retry strobe.
- R9: The `MAX_ATTEMPTS`-th collision of a frame (16 by default) aborts it with `abort_cause_o` = 1. The collision count is cleared by the abort, so the next frame's first collision retries with k = 1.
- R10: Deferral time is not cumulative. After a backoff, the deferral watchdog restarts from zero on re-entering deferral.
- R11: `done_i` during transmission ends the frame and clears the collision count, so the next frame starts again at n = 1.
- R12: `go_o`, `retry_o` and `abort_o` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe per bit time |
| req_i | input | 1 | A frame is ready to send (sampled when idle) |
| crs_i | input | 1 | Carrier sense from the medium |
| col_i | input | 1 | Collision seen during transmission |
| done_i | input | 1 | Current transmission completed without collision |
| backoff_lim_i | input | 2 | Exponent cap code: 0→10, 1→8, 2→4, 3→1 |
| no_retry_i | input | 1 | Make a single attempt only |
| defer_chk_i | input | 1 | Enable the deferral watchdog |
| jumbo_i | input | 1 | Select the long deferral limit |
| go_o | output | 1 | Start-of-attempt strobe |
| retry_o | output | 1 | Collision accepted, backoff started |
| abort_o | output | 1 | Frame abandoned |
| abort_cause_o | output | 2 | 0 none, 1 excessive collisions, 2 excessive deferral; valid with abort_o |

## Verification
Every result is a registered strobe with a fixed latency. `go_o` comes one cycle after carrier-idle is seen in deferral, which is two cycles after a request on a quiet line. `retry_o` or a collision abort comes one cycle after `col_i`. A deferral abort comes one cycle after the tick that crosses the limit. The next `go_o` comes exactly `r`×`SLOT_BITS`+2 cycles after `retry_o` when a tick arrives every cycle. The bench drives and samples on the falling edge and counts edges from each stimulus. It checks each event's cycle exactly, and for backoff it checks that the wait is a whole number of slots with a quotient under the R7 bound, since the random value itself is not predicted.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DEFER   = 3'd1,
    ST_XMIT    = 3'd2,
    ST_BACKOFF = 3'd3,
    ST_ABORT   = 3'd4
  } hdx_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_EXCOL = 2'd1,
    CAUSE_EXDEF = 2'd2
  } hdx_cause_e;

  // Exponent ceiling selected by the two-bit limit code.
  function automatic int unsigned exp_ceiling(input logic [1:0] code);
    case (code)
      2'd0:    return 10;
      2'd1:    return 8;
      2'd2:    return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/hdx_lfsr.sv
module hdx_lfsr #(
  parameter int          W     = 16,
  parameter int          OUT_W = 10,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output logic [OUT_W-1:0] rnd_o
);

  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sr_q <= SEED;
    else if (sr_q[0]) sr_q <= (sr_q >> 1) ^ TAPS;
    else sr_q <= sr_q >> 1;
  end

  assign rnd_o = sr_q[OUT_W-1:0];

  // R7: random source must never lock at zero
  lfsr_alive_chk: assert property (@(posedge clk_i) disable iff (rst_i) sr_q != '0);

endmodule

// File: rtl/hdx_defer_watch.sv
module hdx_defer_watch #(
  parameter int STD_LIMIT   = 24288,
  parameter int JUMBO_LIMIT = 155680
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic active_i,
  input  logic busy_i,
  input  logic tick_i,
  input  logic enable_i,
  input  logic jumbo_i,
  output logic expire_o
);

  localparam int LIM_MAX = (STD_LIMIT > JUMBO_LIMIT) ? STD_LIMIT : JUMBO_LIMIT;
  localparam int CW      = $clog2(LIM_MAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit    = jumbo_i ? CW'(JUMBO_LIMIT) : CW'(STD_LIMIT);
  assign expire_o = enable_i && active_i && busy_i && tick_i && (cnt_q >= limit);

  always_ff @(posedge clk_i) begin
    if (rst_i || !active_i) cnt_q <= '0;
    else if (busy_i && tick_i && cnt_q < CW'(LIM_MAX)) cnt_q <= cnt_q + 1'b1;
  end

  // R3: the deferral count saturates at the larger limit
  defer_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= CW'(LIM_MAX));

  // R10: leaving deferral restarts the count from zero
  defer_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !active_i |=> cnt_q == '0);

endmodule

// File: rtl/hdx_slot_timer.sv
module hdx_slot_timer #(
  parameter int SLOT_BITS = 512,
  parameter int CNT_W     = 10
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] slots_i,
  input  logic             tick_i,
  output logic             zero_o
);

  localparam int PW = (SLOT_BITS > 2) ? $clog2(SLOT_BITS) : 1;

  logic [CNT_W-1:0] rem_q;
  logic [PW-1:0]    phase_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rem_q   <= '0;
      phase_q <= '0;
    end else if (load_i) begin
      rem_q   <= slots_i;
      phase_q <= '0;
    end else if (rem_q != '0 && tick_i) begin
      if (phase_q == PW'(SLOT_BITS - 1)) begin
        phase_q <= '0;
        rem_q   <= rem_q - 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign zero_o = (rem_q == '0);

  // R6: slot phase stays inside one slot
  slot_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    phase_q <= PW'(SLOT_BITS - 1));

  // R6: a pending wait only shrinks
  slot_monotone_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && !zero_o) |=> rem_q <= $past(rem_q));

endmodule

// File: rtl/hdx_txctl.sv
module hdx_txctl
  import hdx_pkg::*;
#(
  parameter int          SLOT_BITS    = 512,
  parameter int          DEFER_STD    = 24288,
  parameter int          DEFER_JUMBO  = 155680,
  parameter int          MAX_ATTEMPTS = 16,
  parameter int          EXP_MAX      = 10,
  parameter int          LFSR_W       = 16,
  parameter logic [15:0] LFSR_TAPS    = 16'hB400
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       tick_i,
  input  logic       req_i,
  input  logic       crs_i,
  input  logic       col_i,
  input  logic       done_i,
  input  logic [1:0] backoff_lim_i,
  input  logic       no_retry_i,
  input  logic       defer_chk_i,
  input  logic       jumbo_i,
  output logic       go_o,
  output logic       retry_o,
  output logic       abort_o,
  output logic [1:0] abort_cause_o
);

  localparam int AW = $clog2(MAX_ATTEMPTS + 1);
  localparam int RW = EXP_MAX;

  hdx_state_e      state_q;
  hdx_cause_e      cause_q;
  logic [AW-1:0]   coll_q;
  logic [AW-1:0]   coll_next;
  logic            give_up;
  logic            bo_load;
  logic            slot_zero;
  logic            defer_expire;
  logic [RW-1:0]   rnd;
  logic [RW-1:0]   rmask;
  logic [RW-1:0]   slots_draw;

  hdx_lfsr #(
    .W(LFSR_W), .OUT_W(RW),
    .TAPS(LFSR_TAPS[LFSR_W-1:0]), .SEED(LFSR_W'(1))
  ) u_lfsr (
    .clk_i(clk_i), .rst_i(rst_i), .rnd_o(rnd)
  );

  hdx_defer_watch #(
    .STD_LIMIT(DEFER_STD), .JUMBO_LIMIT(DEFER_JUMBO)
  ) u_defer (
    .clk_i(clk_i), .rst_i(rst_i),
    .active_i(state_q == ST_DEFER), .busy_i(crs_i), .tick_i(tick_i),
    .enable_i(defer_chk_i), .jumbo_i(jumbo_i), .expire_o(defer_expire)
  );

  hdx_slot_timer #(
    .SLOT_BITS(SLOT_BITS), .CNT_W(RW)
  ) u_slot (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(bo_load),
    .slots_i(slots_draw), .tick_i(tick_i), .zero_o(slot_zero)
  );

  // Exponent k = min(n, ceiling) and the mask of k low bits
  always_comb begin
    int unsigned ceil_k;
    int unsigned k;
    ceil_k = exp_ceiling(backoff_lim_i);
    if (ceil_k > EXP_MAX) ceil_k = EXP_MAX;
    k = (int'(coll_next) < int'(ceil_k)) ? int'(coll_next) : ceil_k;
    for (int i = 0; i < RW; i++) rmask[i] = (i < int'(k));
  end

  assign coll_next  = coll_q + 1'b1;
  assign give_up    = no_retry_i || (coll_next >= AW'(MAX_ATTEMPTS));
  assign bo_load    = (state_q == ST_XMIT) && col_i && !give_up;
  assign slots_draw = rnd & rmask;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      cause_q <= CAUSE_NONE;
      coll_q  <= '0;
      go_o    <= 1'b0;
      retry_o <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      go_o    <= 1'b0;
      retry_o <= 1'b0;
      abort_o <= 1'b0;
      cause_q <= CAUSE_NONE;
      case (state_q)
        ST_IDLE: if (req_i) state_q <= ST_DEFER;
        ST_DEFER: begin
          if (!crs_i) begin
            state_q <= ST_XMIT;
            go_o    <= 1'b1;
          end else if (defer_expire) begin
            state_q <= ST_ABORT;
            abort_o <= 1'b1;
            cause_q <= CAUSE_EXDEF;
          end
        end
        ST_XMIT: begin
          if (col_i) begin
            if (give_up) begin
              state_q <= ST_ABORT;
              abort_o <= 1'b1;
              cause_q <= CAUSE_EXCOL;
            end else begin
              state_q <= ST_BACKOFF;
              retry_o <= 1'b1;
              coll_q  <= coll_next;
            end
          end else if (done_i) begin
            state_q <= ST_IDLE;
            coll_q  <= '0;
          end
        end
        ST_BACKOFF: if (slot_zero) state_q <= ST_DEFER;
        ST_ABORT: begin
          state_q <= ST_IDLE;
          coll_q  <= '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign abort_cause_o = cause_q;

  // R12
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones({go_o, retry_o, abort_o}) <= 1);

  // R12
  go_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    go_o |=> !go_o);

  // R6
  retry_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    retry_o |=> !go_o);

  // R8
  no_retry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_XMIT && col_i && no_retry_i) |=> (abort_o && abort_cause_o == CAUSE_EXCOL));

  // R9
  attempt_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    coll_q < AW'(MAX_ATTEMPTS));

  // R3
  abort_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    abort_o |-> abort_cause_o != CAUSE_NONE);

  // R4
  no_defer_abort_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_DEFER && !defer_chk_i) |=> !abort_o);

endmodule

// File: tb/test_hdx_txctl.sv
module test_hdx_txctl;

  localparam int SLOT = 8;
  localparam int DSTD = 40;
  localparam int DJUM = 100;

  logic clk = 1'b0;
  logic rst_i = 1'b1, tick_i = 1'b1, req_i = 1'b0, crs_i = 1'b0, col_i = 1'b0;
  logic done_i = 1'b0, no_retry_i = 1'b0, defer_chk_i = 1'b0, jumbo_i = 1'b0;
  logic [1:0] bl_i = 2'd0;
  logic go_o, retry_o, abort_o;
  logic [1:0] abort_cause_o;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  hdx_txctl #(.SLOT_BITS(SLOT), .DEFER_STD(DSTD), .DEFER_JUMBO(DJUM)) i_hdx_txctl (
    .clk_i(clk), .rst_i(rst_i), .tick_i(tick_i), .req_i(req_i), .crs_i(crs_i),
    .col_i(col_i), .done_i(done_i), .backoff_lim_i(bl_i), .no_retry_i(no_retry_i),
    .defer_chk_i(defer_chk_i), .jumbo_i(jumbo_i), .go_o(go_o), .retry_o(retry_o),
    .abort_o(abort_o), .abort_cause_o(abort_cause_o)
  );

  // chk, jumbo, carrier-busy cycles
  localparam int DV [8][3] = '{
    '{1, 0, 0}, '{1, 0, 5}, '{1, 0, 41}, '{1, 0, 42},
    '{0, 0, 120}, '{1, 1, 60}, '{1, 1, 101}, '{1, 1, 102}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ev: 1 go, 2 abort, 3 retry
  task automatic wait_ev(input int lim, output int c, output int ev);
    c = 0; ev = 0;
    while (ev == 0 && c < lim) begin
      @(negedge clk);
      c++;
      if (go_o) ev = 1;
      else if (abort_o) ev = 2;
      else if (retry_o) ev = 3;
    end
  endtask

  function automatic int ceil_of(input int bl);
    case (bl)
      0: return 10;
      1: return 8;
      2: return 4;
      default: return 1;
    endcase
  endfunction

  task automatic finish_frame();
    done_i = 1'b1; req_i = 1'b0;
    @(negedge clk);
    done_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_defer(input int chk, input int jum, input int hold);
    int c, ev, thr, exp_ev, exp_c;
    string tag;
    defer_chk_i = chk[0]; jumbo_i = jum[0]; bl_i = 2'd3; no_retry_i = 1'b0;
    req_i = 1'b1; crs_i = (hold > 0);
    c = 0; ev = 0;
    while (ev == 0 && c < 2000) begin
      @(negedge clk);
      c++;
      if (go_o) ev = 1;
      else if (abort_o) ev = 2;
      else if (retry_o) ev = 3;
      if (c == hold) crs_i = 1'b0;
    end
    thr = jum ? DJUM : DSTD;
    if (chk != 0 && hold >= thr + 2) begin
      exp_ev = 2; exp_c = thr + 2; tag = "R3 deferral abort";
    end else begin
      exp_ev = 1; exp_c = ((hold < 1) ? 1 : hold) + 1;
      tag = (chk == 0) ? "R4 unbounded deferral" : "R2 go after carrier idle";
    end
    check(ev == exp_ev, {tag, " event"}, ev, exp_ev);
    check(c == exp_c, {tag, " cycle"}, c, exp_c);
    if (exp_ev == 2) check(abort_cause_o == 2'd2, "R3 cause", abort_cause_o, 2);
    req_i = 1'b0; crs_i = 1'b0;
    if (ev == 1) finish_frame();
    else repeat (2) @(negedge clk);
  endtask

  task automatic run_frame(input int bl, input int nr, input int ncol, input string tag);
    int c, ev, r, k;
    bl_i = bl[1:0]; no_retry_i = nr[0]; defer_chk_i = 1'b0; jumbo_i = 1'b0;
    req_i = 1'b1; crs_i = 1'b0;
    wait_ev(10, c, ev);
    check(ev == 1 && c == 2, "R2 first go on quiet line", c, 2);
    for (int n = 1; n <= ncol; n++) begin
      col_i = 1'b1;
      @(negedge clk);
      col_i = 1'b0;
      if (nr != 0 || n == 16) begin
        check(abort_o && !retry_o && abort_cause_o == 2'd1,
              (nr != 0) ? "R8 single attempt abort" : "R9 collision limit abort",
              {abort_o, retry_o, abort_cause_o}, 4'b1001);
        req_i = 1'b0;
        repeat (2) @(negedge clk);
        return;
      end
      check(retry_o && !go_o && !abort_o, "R12 retry strobe alone", retry_o, 1);
      wait_ev(20000, c, ev);
      check(ev == 1, "R6 go after backoff", ev, 1);
      r = (c - 2) / SLOT;
      check(c >= 2 && ((c - 2) % SLOT) == 0, "R6 whole slots", c, r * SLOT + 2);
      k = (n < ceil_of(bl)) ? n : ceil_of(bl);
      check(r < (1 << k), {tag, " exponent bound"}, r, (1 << k) - 1);
    end
    finish_frame();
  endtask

  initial begin
    int c, ev;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(!go_o && !retry_o && !abort_o && abort_cause_o == 2'd0, "R1 in reset",
          {go_o, retry_o, abort_o}, 0);
    rst_i = 1'b0;
    @(negedge clk);
    check(!go_o && !retry_o && !abort_o && abort_cause_o == 2'd0, "R1 after reset",
          {go_o, retry_o, abort_o}, 0);

    // table walk: R2, R3, R4
    for (int i = 0; i < 8; i++) run_defer(DV[i][0], DV[i][1], DV[i][2]);

    // R5: no ticks, no deferral progress
    defer_chk_i = 1'b1; jumbo_i = 1'b0; tick_i = 1'b0; req_i = 1'b1; crs_i = 1'b1;
    ev = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (go_o || abort_o || retry_o) ev++;
    end
    check(ev == 0, "R5 no event without ticks", ev, 0);
    tick_i = 1'b1; crs_i = 1'b0;
    wait_ev(10, c, ev);
    check(ev == 1 && c == 1, "R5 go once carrier idle", c, 1);
    finish_frame();

    // R7 exponent caps, R6 slot multiples
    run_frame(3, 0, 3, "R7 cap 1");
    run_frame(2, 0, 6, "R7 cap 4");
    run_frame(1, 0, 9, "R7 cap 8");
    run_frame(0, 0, 11, "R7 cap 10");
    // R11: fresh frame starts at n = 1 after done
    run_frame(0, 0, 1, "R11 count cleared by done");
    // R9: 16th collision aborts, next frame restarts at n = 1
    run_frame(2, 0, 16, "R9 run to limit");
    run_frame(0, 0, 1, "R9 count cleared by abort");
    // R8
    run_frame(3, 1, 1, "R8");

    // R10: deferral restarts after backoff
    bl_i = 2'd3; no_retry_i = 1'b0; defer_chk_i = 1'b1; jumbo_i = 1'b0;
    req_i = 1'b1; crs_i = 1'b1;
    repeat (30) @(negedge clk);
    crs_i = 1'b0;
    wait_ev(10, c, ev);
    check(ev == 1, "R10 first go", ev, 1);
    col_i = 1'b1;
    @(negedge clk);
    col_i = 1'b0; crs_i = 1'b1;
    check(retry_o == 1'b1, "R10 retry", retry_o, 1);
    wait_ev(2000, c, ev);
    check(ev == 2 && abort_cause_o == 2'd2, "R10 abort cause", abort_cause_o, 2);
    check(c == DSTD + 2 || c == SLOT + DSTD + 2, "R10 full limit after backoff", c, DSTD + 2);
    req_i = 1'b0; crs_i = 1'b0;
    repeat (3) @(negedge clk);

    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule